// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus (clock line SCL, open-drain data line SDA). It lets a bus host reach a small internal bank of byte-wide registers. Every access goes through a pointer register that keeps its value from one transaction to the next. A write transaction carries one byte or two. The first byte always loads the pointer. A second byte, if present, is stored into the register the pointer selects. A read transaction always returns exactly one byte, taken from the register the pointer selects. The pointer does not advance after a read or a write.

Both bus lines are brought into the system clock domain through a two-flop synchronizer. An edge detector follows the synchronizer and finds SCL edges and start and stop conditions. The slave pulls SDA low only through an output-enable, and the pad logic outside the block turns that enable into an open-drain drive. Each register update also appears on a one-cycle parallel write port, so that surrounding logic can follow changes to the bank.

Top module: `ptr_reg_slave`

## Requirements
- R1: The first byte after a start is shifted in MSB first. Its upper seven bits are the slave address and its lowest bit selects direction (0 = write, 1 = read). The slave pulls SDA low for the ninth clock only when the address equals SLAVE_ADDR (default 7'h4C).
- R2: In a write transaction, the byte after the address is stored in the pointer. A transaction that stops after this byte changes no register and produces no write strobe.
- R3: A second write byte is stored into the register the pointer selects. The write port shows a one-cycle reg_we pulse carrying reg_waddr = pointer and reg_wdata = byte.
- R4: A read transaction shifts out, MSB first, the register selected by the pointer that an earlier write set. The pointer keeps its value across transactions, so repeated reads return the same register.
- R5: After the eighth data bit of a read, the slave releases SDA, including during the host's no-acknowledge clock, and does not drive it again until the next start.
- R6: The slave acknowledges the pointer byte and the second write byte by pulling SDA low for the ninth clock. It does not acknowledge any write byte after the second, and such a byte is not written.
- R7: Pointer values of NUM_REGS (16) or above read as 8'h00. A data byte written at such a pointer is still acknowledged, but it produces no write strobe.
- R8: After an address that does not match, the slave leaves SDA released and ignores every following byte until the next start.
- R9: A start seen in the middle of a transaction aborts it and begins a new address phase. A stop returns the slave to idle with SDA released.
- R10: Synchronous active-low reset releases SDA, clears the pointer to 0, and clears every register to 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are oversampled on it |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (the wired value) |
| sda_oe | output | 1 | 1 = pull SDA low; 0 = release the line |
| reg_we | output | 1 | One-cycle strobe for a register update |
| reg_waddr | output | IDX_W (4) | Index of the register being written |
| reg_wdata | output | DATA_W (8) | Byte being written |

## Verification
If the bit counter or the byte index goes wrong, the acknowledge moves to a different clock slot. A comparison of SDA made during every SCL phase catches this on the first byte boundary it affects. A wrong pointer, a missing range check or a stale shift register appears at the ports in one of two places: as a wrong bit in the very next read byte, or as an unexpected, missing or misdirected reg_we entry when the transaction ends. A state that fails to leave its phase after a start, a stop or a non-matching address keeps SDA driven or acknowledging during the following bit slots. The slot-by-slot model reports this within one byte.

// File: rtl/ptr_slv_pkg.sv
// Package: shared types for the pointer-addressed serial slave.
// Assumes: byte-wide bus transfers; nothing vendor-specific.
package ptr_slv_pkg;

    // Protocol phases of the slave engine.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // ignoring bus until next start
        PH_RECV = 2'd1,   // shifting a byte in from the host
        PH_ACKN = 2'd2,   // holding SDA low for the ninth clock
        PH_SEND = 2'd3    // shifting the read byte out
    } slv_phase_t;

endpackage

// File: rtl/bus_sync_detect.sv
// Module: bus_sync_detect
// Brings SCL/SDA into the system clock domain through a STAGES-deep
// synchronizer, then flags SCL edges and start/stop conditions.
// Assumes: each SCL level lasts at least three system clocks; lines idle high.
module bus_sync_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    // Synchronizer chains plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_raw};
            sda_q <= {sda_q[STAGES-2:0], sda_raw};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Edge and bus-condition decode from current vs previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/reg_bank.sv
// Module: reg_bank
// NUM_REGS registers of DATA_W bits with one write port and one read port.
// Reads at indices outside the bank return zero; writes are expected
// to be range-checked by the caller.
// Assumes: NUM_REGS <= 2**DATA_W.
module reg_bank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W:0] LIMIT = (DATA_W+1)'(NUM_REGS);

    logic [DATA_W-1:0] mem [NUM_REGS];

    // Storage with synchronous clear and single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read mux; out-of-range pointer yields zero.
    always_comb begin
        if ({1'b0, raddr} < LIMIT) rdata = mem[raddr[IDX_W-1:0]];
        else                       rdata = '0;
    end

endmodule

// File: rtl/slave_engine.sv
// Module: slave_engine
// Bit/byte sequencer for the pointer-addressed slave: address match,
// acknowledge timing, pointer load, register write, read shifting.
// Assumes: inputs come from bus_sync_detect; DATA_W = 8 (address is 7 bits + R/W).
module slave_engine
    import ptr_slv_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h4C,
    parameter int         NUM_REGS   = 16,
    parameter int         DATA_W     = 8,
    parameter int         IDX_W      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ptr,
    output logic              sda_oe,
    output logic              we,
    output logic [IDX_W-1:0]  waddr,
    output logic [DATA_W-1:0] wdata
);

    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  BYTE_END = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0]  LAST_TX  = CNT_W'(DATA_W - 1);
    localparam logic [DATA_W:0]   LIMIT    = (DATA_W+1)'(NUM_REGS);

    slv_phase_t        phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        byte_idx;   // 0 addr, 1 pointer, 2 data, 3 beyond
    logic [DATA_W-1:0] shreg;
    logic              rd_dir;
    logic              ptr_ok;

    // Pointer range check used for write suppression.
    assign ptr_ok = ({1'b0, ptr} < LIMIT);

    // Main sequencer: bus conditions first, then per-phase SCL edge handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            rd_dir   <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            we       <= 1'b0;
            waddr    <= '0;
            wdata    <= '0;
        end else begin
            we <= 1'b0;
            if (start_det) begin
                phase    <= PH_RECV;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    PH_RECV: begin
                        if (scl_rise && bit_cnt != BYTE_END) begin
                            shreg   <= {shreg[DATA_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BYTE_END) begin
                            bit_cnt <= '0;
                            case (byte_idx)
                                2'd0: begin
                                    if (shreg[DATA_W-1:1] == SLAVE_ADDR) begin
                                        rd_dir <= shreg[0];
                                        sda_oe <= 1'b1;
                                        phase  <= PH_ACKN;
                                    end else begin
                                        phase  <= PH_IDLE;
                                    end
                                end
                                2'd1: begin
                                    ptr    <= shreg;
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACKN;
                                end
                                2'd2: begin
                                    we     <= ptr_ok;
                                    waddr  <= ptr[IDX_W-1:0];
                                    wdata  <= shreg;
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACKN;
                                end
                                default: phase <= PH_IDLE;
                            endcase
                        end
                    end
                    PH_ACKN: begin
                        if (scl_fall) begin
                            if (byte_idx != 2'd3) byte_idx <= byte_idx + 1'b1;
                            bit_cnt <= '0;
                            if (byte_idx == 2'd0 && rd_dir) begin
                                phase  <= PH_SEND;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[DATA_W-1];
                            end else begin
                                phase  <= PH_RECV;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_SEND: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST_TX) begin
                                phase  <= PH_IDLE;
                                sda_oe <= 1'b0;
                            end else begin
                                shreg   <= {shreg[DATA_W-2:0], 1'b0};
                                sda_oe  <= ~shreg[DATA_W-2];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ptr_reg_slave.sv
// Module: ptr_reg_slave (top)
// Two-wire slave giving pointer-based access to a small register bank.
// Assumes: open-drain pad outside (sda_oe=1 pulls low); SCL levels last
// at least three clk cycles; no clock stretching.
module ptr_reg_slave #(
    parameter logic [6:0] SLAVE_ADDR = 7'h4C,
    parameter int         NUM_REGS   = 16,
    parameter int         DATA_W     = 8,
    parameter int         IDX_W      = $clog2(NUM_REGS),
    parameter int         SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_waddr,
    output logic [DATA_W-1:0] reg_wdata
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DATA_W-1:0] ptr, rd_data;

    bus_sync_detect #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    slave_engine #(
        .SLAVE_ADDR(SLAVE_ADDR), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe), .we(reg_we),
        .waddr(reg_waddr), .wdata(reg_wdata)
    );

    reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
        .wdata(reg_wdata), .raddr(ptr), .rdata(rd_data)
    );

endmodule

// File: rtl/ptr_reg_slave_chk.sv
// Module: ptr_reg_slave_chk
// Protocol properties of ptr_reg_slave, attached by bind.
// Assumes: synchronized SCL and bus-condition flags from the top's nets.
module ptr_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic reg_we
);

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);                       // R6
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);                                      // R9
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);                                       // R9
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);                                         // R3
    AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> sda_oe);                                          // R6

endmodule

bind ptr_reg_slave ptr_reg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .reg_we(reg_we)
);

// File: tb/sim_ptr_reg_slave.sv
// Bench: behavioural bus host plus reference model; SDA drive compared
// on every clock of each settled SCL phase, writes compared by queue.
module sim_ptr_reg_slave;

    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] DEV = 7'h4C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, reg_we;
    logic [3:0] reg_waddr;
    logic [7:0] reg_wdata;
    logic       sda_line;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bit    cmp_en = 0;
    logic  exp_oe = 1'b0;
    string cur_req = "R10";

    logic [7:0]  ref_regs [16];
    int          ref_ptr = 0;
    logic [11:0] exp_q [$];
    logic [11:0] obs_q [$];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
    );

    // Per-clock comparison of the slave's SDA drive against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            total++;
            if (sda_oe !== exp_oe) begin
                bad++;
                $display("FAIL %s: sda_oe actual=%0b expected=%0b at %0t", cur_req, sda_oe, exp_oe, $time);
            end
        end
    end

    // Capture of the parallel write port.
    always @(negedge clk) begin
        if (rst_n && reg_we) obs_q.push_back({reg_waddr, reg_wdata});
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One SCL low+high period: host drives mbit, slave drive must equal e.
    task automatic slot(input logic mbit, input logic e, input string req, output logic seen);
        cmp_en = 0;
        scl_m = 1'b0;
        wclk(3);
        sda_m = mbit;
        exp_oe = e;
        cur_req = req;
        wclk(3);
        cmp_en = 1;
        wclk(4);
        scl_m = 1'b1;
        wclk(5);
        seen = sda_line;
        wclk(5);
        cmp_en = 0;
    endtask

    task automatic start_c();
        cmp_en = 0;
        scl_m = 1'b0; wclk(5);
        sda_m = 1'b1; wclk(5);
        scl_m = 1'b1; wclk(10);
        sda_m = 1'b0; wclk(10);
    endtask

    task automatic stop_c(input string req);
        cmp_en = 0;
        scl_m = 1'b0; wclk(5);
        sda_m = 1'b0; wclk(5);
        scl_m = 1'b1; wclk(10);
        sda_m = 1'b1; wclk(10);
        chk(sda_oe == 1'b0, req, "sda_oe after stop", sda_oe, 0);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, req, s);
        slot(1'b1, ack, req, s);
        chk(s == ~ack, req, "ack level on ninth clock", s, ~ack);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input string req);
        logic s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            slot(1'b1, ~exp[i], req, s);
            got[i] = s;
        end
        chk(got == exp, req, "read byte", got, exp);
        slot(1'b1, 1'b0, "R5", s);   // host no-acknowledge; slave released
    endtask

    // Model transactions.
    task automatic wr_tx(input logic [6:0] a, input logic [7:0] p, input int nbytes,
                         input logic [7:0] d, input logic [7:0] d2, input string req);
        bit m = (a == DEV);
        start_c();
        send_byte({a, 1'b0}, m, m ? "R1" : "R8");
        send_byte(p, m, m ? "R2" : "R8");
        if (m) ref_ptr = p;
        if (nbytes >= 2) begin
            send_byte(d, m, m ? "R6" : "R8");
            if (m && ref_ptr < 16) begin
                ref_regs[ref_ptr] = d;
                exp_q.push_back({4'(ref_ptr), d});
            end
        end
        if (nbytes >= 3) send_byte(d2, 1'b0, m ? "R6" : "R8");
        stop_c(req);
    endtask

    task automatic rd_tx(input string req);
        logic [7:0] e = (ref_ptr < 16) ? ref_regs[ref_ptr] : 8'h00;
        start_c();
        send_byte({DEV, 1'b1}, 1'b1, "R1");
        recv_byte(e, req);
        stop_c("R5");
    endtask

    task automatic cmp_writes(input string req);
        chk(obs_q.size() == exp_q.size(), req, "write strobe count", obs_q.size(), exp_q.size());
        while (obs_q.size() > 0 && exp_q.size() > 0) begin
            logic [11:0] o = obs_q.pop_front();
            logic [11:0] x = exp_q.pop_front();
            chk(o == x, req, "write port {addr,data}", o, x);
        end
        obs_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic s;
        for (int i = 0; i < 16; i++) ref_regs[i] = 8'h00;
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        chk(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);
        chk(reg_we == 1'b0, "R10", "reg_we after reset", reg_we, 0);

        // R10: cleared bank, pointer 0 read first
        rd_tx("R10");
        wr_tx(DEV, 8'h05, 1, 8'h00, 8'h00, "R2");
        rd_tx("R10");
        cmp_writes("R2");

        // R3: pointer plus data
        wr_tx(DEV, 8'h03, 2, 8'hA5, 8'h00, "R3");
        cmp_writes("R3");
        wr_tx(DEV, 8'h0E, 2, 8'h5A, 8'h00, "R3");
        cmp_writes("R3");

        // R2 + R4: pointer-only then repeated reads, no auto-increment
        wr_tx(DEV, 8'h03, 1, 8'h00, 8'h00, "R2");
        cmp_writes("R2");
        rd_tx("R4");
        rd_tx("R4");
        wr_tx(DEV, 8'h0E, 1, 8'h00, 8'h00, "R2");
        rd_tx("R4");

        // R6: third write byte not acknowledged and not written
        wr_tx(DEV, 8'h07, 3, 8'h3C, 8'h99, "R6");
        cmp_writes("R6");
        rd_tx("R6");

        // R7: out-of-range pointer
        wr_tx(DEV, 8'h20, 2, 8'h55, 8'h00, "R7");
        cmp_writes("R7");
        rd_tx("R7");
        wr_tx(DEV, 8'h10, 1, 8'h00, 8'h00, "R7");
        rd_tx("R7");

        // R8: non-matching addresses ignored
        wr_tx(7'h4D, 8'h03, 2, 8'hFF, 8'h00, "R8");
        wr_tx(7'h0C, 8'h07, 2, 8'h11, 8'h00, "R8");
        cmp_writes("R8");
        wr_tx(DEV, 8'h03, 1, 8'h00, 8'h00, "R8");
        rd_tx("R8");

        // R9: start in the middle of a data byte aborts
        start_c();
        send_byte({DEV, 1'b0}, 1'b1, "R9");
        send_byte(8'h02, 1'b1, "R9");
        ref_ptr = 2;
        for (int i = 0; i < 4; i++) slot(1'b0, 1'b0, "R9", s);
        start_c();
        send_byte({DEV, 1'b0}, 1'b1, "R9");
        send_byte(8'h04, 1'b1, "R9");
        ref_ptr = 4;
        send_byte(8'h77, 1'b1, "R9");
        ref_regs[4] = 8'h77;
        exp_q.push_back({4'd4, 8'h77});
        stop_c("R9");
        cmp_writes("R9");
        wr_tx(DEV, 8'h02, 1, 8'h00, 8'h00, "R9");
        rd_tx("R9");
        wr_tx(DEV, 8'h04, 1, 8'h00, 8'h00, "R9");
        rd_tx("R9");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule